// File: doc/BRIEF.md
# Page Program Buffer Loader

This block collects the data bytes of a page program command into a 128-byte page buffer. When the command begins, the block takes in the page number and the starting byte address. It empties the buffer and arms itself, but only if the starting byte address is zero. Any other starting address makes the command invalid, and the block stays idle until the next command.

While the block is armed, each complete 8-bit data byte is written at the current write pointer. That slot is then marked valid and the pointer moves forward. After the last slot the pointer returns to slot 0, so later bytes overwrite earlier ones. A byte that arrives with fewer than eight bits counted is thrown away.

When chip select rises on an armed command that holds at least one complete byte, the block emits a one-cycle program-start strobe. The array writer then reads the buffer through a random-access port and uses the per-byte valid marks to skip the slots that were never loaded. The serial shifter upstream and the array timing downstream belong to other blocks.

Top module: `pg_load_buf`

## Requirements
- R1: After reset, `prog_start` is 0, every bit of `byte_valid` is 0, and every buffer slot reads 8'hFF.
- R2: A `cmd_start` pulse clears every slot to 8'hFF and every valid mark to 0 on the next edge. The same edge captures `cmd_page`, and `prog_page` shows it from then on.
- R3: A command whose `cmd_byte_addr` is not 0 is rejected. Data bytes sent after it are not stored, and a later `cs_rise` gives no `prog_start`.
- R4: While armed, a strobe with `data_bits` equal to 8 stores `data_byte` at the write pointer and sets that slot's valid mark. The pointer starts at slot 0 and moves up by one per stored byte.
- R5: After slot 127 the write pointer returns to slot 0. Byte k of the command ends up in slot k mod 128, and the latest byte for a slot wins.
- R6: A strobe with `data_bits` below 8 stores nothing, sets no valid mark and leaves the write pointer where it is.
- R7: A `cs_rise` on an armed command with one or more stored bytes makes `prog_start` 1 for exactly the one cycle after the `cs_rise` edge. The armed state then ends.
- R8: A `cs_rise` on an armed command with no stored bytes gives no `prog_start` and ends the armed state.
- R9: Data strobes and `cs_rise` pulses that come while no command is armed change neither the buffer contents nor the valid marks, and give no `prog_start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_start | input | 1 | One-cycle pulse that begins a page program command |
| cmd_page | input | 16 | Page number that comes with the command |
| cmd_byte_addr | input | 7 | Starting byte address that comes with the command; must be 0 |
| data_strobe | input | 1 | A data byte from the serial stream is present |
| data_byte | input | 8 | Data byte, MSB first as received |
| data_bits | input | 4 | Number of bits clocked into this byte (0 to 8) |
| cs_rise | input | 1 | One-cycle pulse when chip select rises |
| rd_idx | input | 7 | Buffer read index |
| rd_byte | output | 8 | Buffer contents at `rd_idx` (combinational) |
| byte_valid | output | 128 | Per-slot valid marks |
| prog_start | output | 1 | One-cycle strobe that starts the array write |
| prog_page | output | 16 | Captured page number for the array write |

## Verification
The load is tried with runs of 1, 2, 63, 127, 128, 129 and 200 complete bytes, each run with its own value pattern. Across these runs the results tell apart a partly filled page, an exactly full page and pointer wrap with overwrite. The expected content and valid mark of every slot are worked out arithmetically from the run length.

A run that ends with a partial byte shows that short bytes are dropped without moving the pointer. Several non-zero start addresses, a close with no bytes and traffic while idle each check that nothing gets stored and no strobe is given.

// File: rtl/pgb_pkg.sv
// Package: shared types for the page program buffer loader.
// Assumes: nothing beyond IEEE 1800-2017.
package pgb_pkg;

    // Loader state: idle, or armed by an accepted page program command
    typedef enum logic {
        LD_IDLE  = 1'b0,
        LD_ARMED = 1'b1
    } ld_state_e;

    // Value that a cleared buffer slot reads back (erased pattern)
    localparam logic [7:0] SLOT_BLANK = 8'hFF;

endpackage

// File: rtl/pgb_cmd_latch.sv
// Module: pgb_cmd_latch
// Captures the page number of each page program command and decides
// whether the command's starting byte address is acceptable (must be 0).
// Assumes: cmd_start is a single-cycle pulse.
module pgb_cmd_latch #(
    parameter int PAGE_W = 16,
    parameter int AW     = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_start,
    input  logic [PAGE_W-1:0] cmd_page,
    input  logic [AW-1:0]     cmd_byte_addr,
    output logic              cmd_ok,
    output logic [PAGE_W-1:0] page_q
);

    // Accept only a command whose start address is slot zero
    always_comb cmd_ok = (cmd_byte_addr == '0);

    // Hold the page number of the latest command
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= '0;
        else if (cmd_start)
            page_q <= cmd_page;
    end

endmodule

// File: rtl/pgb_ctrl.sv
// Module: pgb_ctrl
// Arm/idle sequencing, write pointer with in-page wrap, complete-byte
// filter and program-start strobe issued on chip select rise.
// Assumes: cmd_start and cs_rise do not fall in the same cycle; if they
// do, cmd_start wins.
module pgb_ctrl
    import pgb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int AW         = $clog2(PAGE_BYTES),
    parameter int BC_W       = $clog2(DATA_W + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_start,
    input  logic            cmd_ok,
    input  logic            data_strobe,
    input  logic [BC_W-1:0] data_bits,
    input  logic            cs_rise,
    output logic            buf_clear,
    output logic            wr_en,
    output logic [AW-1:0]   wr_idx,
    output logic            armed,
    output logic            prog_start
);

    localparam logic [AW-1:0]   LAST_IDX  = AW'(PAGE_BYTES - 1);
    localparam logic [BC_W-1:0] FULL_BITS = BC_W'(DATA_W);

    ld_state_e     state_q;
    logic [AW-1:0] ptr_q;
    logic          loaded_q;
    logic          byte_full;

    // A byte counts only when all of its bits were clocked in
    always_comb byte_full = (data_bits == FULL_BITS);

    // Write strobe and target slot for the storage
    always_comb begin
        armed     = (state_q == LD_ARMED);
        wr_en     = armed && data_strobe && byte_full && !cmd_start;
        wr_idx    = ptr_q;
        buf_clear = cmd_start;
    end

    // State, pointer, load flag and program strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= LD_IDLE;
            ptr_q      <= '0;
            loaded_q   <= 1'b0;
            prog_start <= 1'b0;
        end else begin
            prog_start <= 1'b0;
            if (cmd_start) begin
                state_q  <= cmd_ok ? LD_ARMED : LD_IDLE;
                ptr_q    <= '0;
                loaded_q <= 1'b0;
            end else begin
                if (wr_en) begin
                    ptr_q    <= (ptr_q == LAST_IDX) ? '0 : ptr_q + AW'(1);
                    loaded_q <= 1'b1;
                end
                if (armed && cs_rise) begin
                    state_q    <= LD_IDLE;
                    loaded_q   <= 1'b0;
                    prog_start <= loaded_q || wr_en;
                end
            end
        end
    end

endmodule

// File: rtl/pgb_store.sv
// Module: pgb_store
// Page buffer storage: one data register and one valid mark per slot,
// cleared as a whole, written one slot at a time, read combinationally.
// Assumes: at most one write per cycle; clear has priority over write.
module pgb_store
    import pgb_pkg::*;
#(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int AW         = $clog2(PAGE_BYTES)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  clear,
    input  logic                  wr_en,
    input  logic [AW-1:0]         wr_idx,
    input  logic [DATA_W-1:0]     wr_data,
    input  logic [AW-1:0]         rd_idx,
    output logic [DATA_W-1:0]     rd_data,
    output logic [PAGE_BYTES-1:0] valid
);

    localparam logic [DATA_W-1:0] BLANK = DATA_W'(SLOT_BLANK);

    logic [DATA_W-1:0] slot_data [PAGE_BYTES];

    for (genvar g = 0; g < PAGE_BYTES; g++) begin : g_slot
        logic [DATA_W-1:0] q;
        logic              v;
        logic              hit;

        // Decode whether this slot is the write target
        always_comb hit = wr_en && (wr_idx == AW'(g));

        // Slot register: reset/clear to blank, load on hit
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                q <= BLANK;
                v <= 1'b0;
            end else if (hit) begin
                q <= wr_data;
                v <= 1'b1;
            end
        end

        assign slot_data[g] = q;
        assign valid[g]     = v;
    end

    // Random-access read port for the array writer
    always_comb rd_data = slot_data[rd_idx];

endmodule

// File: rtl/pg_load_buf.sv
// Module: pg_load_buf (top)
// Page program buffer loader: arms on a page program command with start
// address 0, stores complete bytes with in-page wrap, and strobes the
// array write on chip select rise when at least one byte was stored.
// Assumes: the serial shifter presents each byte once with its bit count.
module pg_load_buf #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int PAGE_W     = 16,
    parameter int AW         = $clog2(PAGE_BYTES),
    parameter int BC_W       = $clog2(DATA_W + 1)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_start,
    input  logic [PAGE_W-1:0]     cmd_page,
    input  logic [AW-1:0]         cmd_byte_addr,
    input  logic                  data_strobe,
    input  logic [DATA_W-1:0]     data_byte,
    input  logic [BC_W-1:0]       data_bits,
    input  logic                  cs_rise,
    input  logic [AW-1:0]         rd_idx,
    output logic [DATA_W-1:0]     rd_byte,
    output logic [PAGE_BYTES-1:0] byte_valid,
    output logic                  prog_start,
    output logic [PAGE_W-1:0]     prog_page
);

    logic          cmd_ok;
    logic          buf_clear;
    logic          wr_en;
    logic [AW-1:0] wr_idx;
    logic          armed;

    pgb_cmd_latch #(.PAGE_W(PAGE_W), .AW(AW)) u_cmd (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_start     (cmd_start),
        .cmd_page      (cmd_page),
        .cmd_byte_addr (cmd_byte_addr),
        .cmd_ok        (cmd_ok),
        .page_q        (prog_page)
    );

    pgb_ctrl #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .AW(AW), .BC_W(BC_W)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_start   (cmd_start),
        .cmd_ok      (cmd_ok),
        .data_strobe (data_strobe),
        .data_bits   (data_bits),
        .cs_rise     (cs_rise),
        .buf_clear   (buf_clear),
        .wr_en       (wr_en),
        .wr_idx      (wr_idx),
        .armed       (armed),
        .prog_start  (prog_start)
    );

    pgb_store #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W), .AW(AW)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (buf_clear),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (data_byte),
        .rd_idx  (rd_idx),
        .rd_data (rd_byte),
        .valid   (byte_valid)
    );

endmodule

// File: rtl/pgb_checker.sv
// Module: pgb_checker
// Temporal properties of the page program buffer loader, bound to the top.
module pgb_checker #(
    parameter int PAGE_BYTES = 128,
    parameter int DATA_W     = 8,
    parameter int AW         = $clog2(PAGE_BYTES),
    parameter int BC_W       = $clog2(DATA_W + 1)
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cmd_start,
    input logic                  data_strobe,
    input logic [BC_W-1:0]       data_bits,
    input logic                  cs_rise,
    input logic [PAGE_BYTES-1:0] byte_valid,
    input logic                  prog_start,
    input logic                  armed,
    input logic [AW-1:0]         wr_idx
);

    localparam logic [BC_W-1:0] FULL_BITS = BC_W'(DATA_W);

    // R2: a command leaves every valid mark cleared
    a_r2_clear_on_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_start |=> (byte_valid == '0));

    // R4: an accepted complete byte marks the slot it was written to
    a_r4_mark_written: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && data_strobe && data_bits == FULL_BITS && !cmd_start)
            |=> byte_valid[$past(wr_idx)]);

    // R6: a short byte changes no valid mark
    a_r6_short_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && data_bits != FULL_BITS && !cmd_start) |=> $stable(byte_valid));

    // R7: the program strobe follows a chip select rise and lasts one cycle
    a_r7_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> $past(cs_rise));
    a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> !prog_start);

    // R8: closing an empty command starts no program
    a_r8_empty_close: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_rise && byte_valid == '0 && !(data_strobe && data_bits == FULL_BITS))
            |=> !prog_start);

    // R9: while idle, nothing but a new command touches the marks
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && !cmd_start) |=> ($stable(byte_valid) && !prog_start));

endmodule

bind pg_load_buf pgb_checker #(
    .PAGE_BYTES (PAGE_BYTES),
    .DATA_W     (DATA_W),
    .AW         (AW),
    .BC_W       (BC_W)
) u_pgb_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_start   (cmd_start),
    .data_strobe (data_strobe),
    .data_bits   (data_bits),
    .cs_rise     (cs_rise),
    .byte_valid  (byte_valid),
    .prog_start  (prog_start),
    .armed       (armed),
    .wr_idx      (wr_idx)
);

// File: tb/pg_load_buf_tb_top.sv
// Bench for pg_load_buf: length sweeps with arithmetic expectations.
`timescale 1ns/1ps
module pg_load_buf_tb_top;

    localparam int NB = 128;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_start = 1'b0;
    logic [15:0] cmd_page = '0;
    logic [6:0]  cmd_byte_addr = '0;
    logic        data_strobe = 1'b0;
    logic [7:0]  data_byte = '0;
    logic [3:0]  data_bits = '0;
    logic        cs_rise = 1'b0;
    logic [6:0]  rd_idx = '0;
    logic [7:0]  rd_byte;
    logic [NB-1:0] byte_valid;
    logic        prog_start;
    logic [15:0] prog_page;

    int n_run = 0;
    int n_fail = 0;
    int prog_cnt = 0;

    always #2.5 clk = ~clk;

    pg_load_buf dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_start(cmd_start), .cmd_page(cmd_page),
        .cmd_byte_addr(cmd_byte_addr), .data_strobe(data_strobe),
        .data_byte(data_byte), .data_bits(data_bits), .cs_rise(cs_rise),
        .rd_idx(rd_idx), .rd_byte(rd_byte), .byte_valid(byte_valid),
        .prog_start(prog_start), .prog_page(prog_page)
    );

    // Count cycles with the program strobe high
    always @(posedge clk) if (prog_start) prog_cnt <= prog_cnt + 1;

    task automatic check(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int seed);
        return 8'((k * 37 + seed) & 255);
    endfunction

    task automatic cmd(input logic [15:0] pg, input logic [6:0] ba);
        @(negedge clk);
        cmd_start = 1'b1; cmd_page = pg; cmd_byte_addr = ba;
        @(negedge clk);
        cmd_start = 1'b0;
    endtask

    task automatic send(input logic [7:0] b, input logic [3:0] bits);
        @(negedge clk);
        data_strobe = 1'b1; data_byte = b; data_bits = bits;
        @(negedge clk);
        data_strobe = 1'b0;
    endtask

    // Raise chip select; check strobe in the following cycle, then gone
    task automatic close(input string req, input int exp);
        @(negedge clk);
        cs_rise = 1'b1;
        @(negedge clk);
        cs_rise = 1'b0;
        check(req, int'(prog_start), exp);
        @(negedge clk);
        check(req, int'(prog_start), 0);
    endtask

    function automatic int popc(input logic [NB-1:0] v);
        int c = 0;
        for (int i = 0; i < NB; i++) c += int'(v[i]);
        return c;
    endfunction

    task automatic read_slot(input int j, output logic [7:0] d);
        rd_idx = 7'(j);
        #0.5;
        d = rd_byte;
    endtask

    // Load n bytes and compare all slots against the wrap arithmetic
    task automatic run_len(input int n, input int seed, input logic [15:0] pg);
        logic [7:0] d;
        int p0;
        cmd(pg, 7'd0);
        check("R2 page", int'(prog_page), int'(pg));
        for (int k = 0; k < n; k++) send(pat(k, seed), 4'd8);
        @(negedge clk);
        check(n > NB ? "R5 count" : "R4 count", popc(byte_valid), (n < NB) ? n : NB);
        for (int j = 0; j < NB; j++) begin
            read_slot(j, d);
            if (j < n) begin
                int k = j + NB * ((n - 1 - j) / NB);
                check(n > NB ? "R5 data" : "R4 data", int'(d), int'(pat(k, seed)));
                check("R4 valid", int'(byte_valid[j]), 1);
            end else begin
                check("R2 blank", int'(d), 8'hFF);
                check("R2 invalid", int'(byte_valid[j]), 0);
            end
        end
        p0 = prog_cnt;
        close("R7 strobe", 1);
        check("R7 once", prog_cnt - p0, 1);
    endtask

    initial begin
        #(5.0 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] d;
        logic [NB-1:0] snap;
        int p0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check("R1 strobe", int'(prog_start), 0);
        check("R1 valid", popc(byte_valid), 0);
        read_slot(0, d);   check("R1 blank", int'(d), 8'hFF);
        read_slot(127, d); check("R1 blank", int'(d), 8'hFF);

        // R4/R5 length sweep
        run_len(1,   3,  16'h1234);
        run_len(2,   11, 16'hFFFF);
        run_len(63,  7,  16'h0001);
        run_len(127, 90, 16'h8000);
        run_len(128, 5,  16'h00A5);
        run_len(129, 44, 16'h5A5A);
        run_len(200, 1,  16'h0F0F);

        // R6: short bytes dropped, pointer not moved
        cmd(16'h0042, 7'd0);
        send(8'h11, 4'd8);
        send(8'h22, 4'd7);
        send(8'h33, 4'd8);
        send(8'h44, 4'd3);
        @(negedge clk);
        check("R6 count", popc(byte_valid), 2);
        read_slot(1, d); check("R6 data", int'(d), 8'h33);
        read_slot(2, d); check("R6 untouched", int'(d), 8'hFF);
        close("R7 strobe after short", 1);

        // R3: non-zero start address rejected
        for (int a = 1; a < 128; a = a * 2 + 1) begin
            p0 = prog_cnt;
            cmd(16'h0777, 7'(a));
            send(8'h5C, 4'd8);
            send(8'h6D, 4'd8);
            @(negedge clk);
            check("R3 no store", popc(byte_valid), 0);
            close("R3 no strobe", 0);
            check("R3 no strobe", prog_cnt - p0, 0);
        end

        // R8: empty command, and only a short byte
        cmd(16'h0100, 7'd0);
        close("R8 empty", 0);
        cmd(16'h0101, 7'd0);
        send(8'hAB, 4'd5);
        close("R8 short only", 0);

        // R9: idle traffic after a completed command
        cmd(16'h0200, 7'd0);
        send(8'h77, 4'd8);
        close("R7 single byte", 1);
        snap = byte_valid;
        send(8'h99, 4'd8);
        send(8'h98, 4'd8);
        p0 = prog_cnt;
        close("R9 idle cs", 0);
        check("R9 marks", int'(byte_valid == snap), 1);
        read_slot(0, d); check("R9 data", int'(d), 8'h77);
        read_slot(1, d); check("R9 data", int'(d), 8'hFF);
        check("R9 no strobe", prog_cnt - p0, 0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule